// File: doc/BRIEF.md
# Predicated vector element sequencer

This block expands one tagged scalar instruction into a run of scalar element operations. It takes a decoded instruction: an opcode, a destination register number and two source register numbers. Each of the three register numbers comes with a flag that marks it as scalar or vector. The instruction also carries a vector length and an optional predicate mask. The block then works as a hardware for-loop. It walks the element index upward from zero. For each element that the predicate allows, it issues one ordinary scalar micro-operation on a valid/ready interface. In that micro-operation, every vector-tagged register number is advanced by the element index, and every scalar-tagged number is passed through unchanged.

While elements remain to be issued, the block holds a stall line for instruction fetch. The element index of the next operation comes from a priority search over the remaining mask bits, so an element that the predicate disables costs no cycle. When the loop ends, a one-cycle completion pulse marks the end of the instruction. A new instruction is accepted only while the block is idle. An instruction whose operands are all scalar behaves exactly like a plain scalar instruction.

Top module: `vec_elem_seq`

## Requirements
- R1: With at least one vector-tagged operand, the issued element indices are exactly the enabled indices from 0 up to VL-1. They are issued in strictly ascending order, each one once, and a vector-tagged register number is issued as (base + index) modulo 128.
- R2: When `in_pred_en` is 1, element i is issued only if bit i of `in_pred` is 1. When `in_pred_en` is 0, all elements below VL are issued.
- R3: `pc_hold` is 1 from the cycle after an accepted instruction until the last enabled element has been accepted. It is 0 in the cycle that `done` is high and in every idle cycle.
- R4: A scalar-tagged register number is issued unchanged for every element. Any mix of scalar and vector tags on the three register numbers is handled this way.
- R5: When all three register numbers are scalar-tagged, exactly one operation is issued, with index 0. VL and the predicate are ignored in this case.
- R6: While `uop_valid` is 1 and `uop_ready` is 0, the presented operation and its index stay unchanged in the next cycle.
- R7: With VL = 0 and at least one vector-tagged operand, nothing is issued, `pc_hold` stays 0, and `done` pulses in the cycle after the instruction is accepted.
- R8: `done` is high for exactly one cycle, namely the cycle after the final enabled element is accepted. Disabled elements take no cycle, so with `uop_ready` held at 1 and N enabled elements, `done` comes N+1 cycles after acceptance.
- R9: Every issued operation carries the instruction's opcode unchanged, with no vector-specific encoding.
- R10: `in_start` is ignored while `in_ready` is 0. Input changes during a run do not alter the operations that are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_start | input | 1 | Instruction present; accepted when `in_ready` is 1 |
| in_ready | output | 1 | Sequencer idle, able to accept an instruction |
| in_op | input | 8 | Scalar opcode |
| in_rd | input | 7 | Destination register base |
| in_ra | input | 7 | First source register base |
| in_rb | input | 7 | Second source register base |
| in_rd_vec | input | 1 | 1 = destination is vector-tagged |
| in_ra_vec | input | 1 | 1 = first source is vector-tagged |
| in_rb_vec | input | 1 | 1 = second source is vector-tagged |
| in_vl | input | 7 | Vector length, 0 to 64 |
| in_pred_en | input | 1 | 1 = apply predicate mask |
| in_pred | input | 64 | Predicate mask, bit i enables element i |
| pc_hold | output | 1 | Fetch stall while elements remain |
| uop_valid | output | 1 | Micro-operation valid |
| uop_ready | input | 1 | Downstream accepts the micro-operation |
| uop_op | output | 8 | Opcode of the micro-operation |
| uop_rd | output | 7 | Stepped destination register |
| uop_ra | output | 7 | Stepped first source register |
| uop_rb | output | 7 | Stepped second source register |
| uop_idx | output | 6 | Element index of the micro-operation |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
A corrupted remaining-element mask shows up at the ports right away. An extra, missing or repeated element index appears on `uop_idx` the first time that element is due. A wrong count also moves the `done` pulse away from its exact N+1 cycle slot. A stepping error shows up on the register ports in the same cycle the element is presented. A stuck busy state appears as `pc_hold` staying high, or `done` recurring, in the cycle right after the expected pulse. The sweep covers every combination of operand tags, several vector lengths including 0 and 64, and several predicate and backpressure patterns.

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int RW    = 7,
  parameter int MAXVL = 64,
  parameter int OPW   = 8,
  localparam int IW   = $clog2(MAXVL),
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_start,
  output logic             in_ready,
  input  logic [OPW-1:0]   in_op,
  input  logic [RW-1:0]    in_rd,
  input  logic [RW-1:0]    in_ra,
  input  logic [RW-1:0]    in_rb,
  input  logic             in_rd_vec,
  input  logic             in_ra_vec,
  input  logic             in_rb_vec,
  input  logic [VLW-1:0]   in_vl,
  input  logic             in_pred_en,
  input  logic [MAXVL-1:0] in_pred,
  output logic             pc_hold,
  output logic             uop_valid,
  input  logic             uop_ready,
  output logic [OPW-1:0]   uop_op,
  output logic [RW-1:0]    uop_rd,
  output logic [RW-1:0]    uop_ra,
  output logic [RW-1:0]    uop_rb,
  output logic [IW-1:0]    uop_idx,
  output logic             done
);

  logic             active;
  logic [MAXVL-1:0] rem, lim, init_mask;
  logic [OPW-1:0]   op_q;
  logic [RW-1:0]    rd_q, ra_q, rb_q;
  logic             rd_v, ra_v, rb_v;
  logic [IW-1:0]    cur;
  logic             any_vec;

  assign any_vec = in_rd_vec | in_ra_vec | in_rb_vec;

  always_comb begin
    for (int i = 0; i < MAXVL; i++) lim[i] = (i < int'(in_vl));
  end

  // all-scalar instructions collapse to a single element 0
  assign init_mask = any_vec ? (lim & (in_pred_en ? in_pred : {MAXVL{1'b1}}))
                             : MAXVL'(1);

  always_comb begin
    cur = '0;
    for (int i = MAXVL - 1; i >= 0; i--) if (rem[i]) cur = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rem    <= '0;
      op_q   <= '0;
      rd_q   <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      rd_v   <= 1'b0;
      ra_v   <= 1'b0;
      rb_v   <= 1'b0;
    end else if (!active) begin
      if (in_start) begin
        active <= 1'b1;
        rem    <= init_mask;
        op_q   <= in_op;
        rd_q   <= in_rd;
        ra_q   <= in_ra;
        rb_q   <= in_rb;
        rd_v   <= in_rd_vec;
        ra_v   <= in_ra_vec;
        rb_v   <= in_rb_vec;
      end
    end else if (rem == '0) begin
      active <= 1'b0;
    end else if (uop_ready) begin
      rem[cur] <= 1'b0;
    end
  end

  assign in_ready  = !active;
  assign uop_valid = active && (rem != '0);
  assign pc_hold   = uop_valid;
  assign done      = active && (rem == '0);
  assign uop_idx   = cur;
  assign uop_op    = op_q;
  assign uop_rd    = rd_v ? rd_q + RW'(cur) : rd_q;
  assign uop_ra    = ra_v ? ra_q + RW'(cur) : ra_q;
  assign uop_rb    = rb_v ? rb_q + RW'(cur) : rb_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_ready |=> uop_valid && $stable(uop_idx) && $stable(uop_rd) && $stable(uop_ra) && $stable(uop_rb)); // R6
  AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_ready |=> !uop_valid || (uop_idx > $past(uop_idx))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !pc_hold && in_ready); // R8
  AST_HOLD_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |=> pc_hold || done); // R3
  AST_ZERO_VL: assert property (@(posedge clk) disable iff (!rst_n)
    in_start && in_ready && any_vec && (in_vl == '0) |=> done && !uop_valid); // R7

endmodule

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_start = 1'b0;
  logic        in_ready;
  logic [7:0]  in_op = '0;
  logic [6:0]  in_rd = '0, in_ra = '0, in_rb = '0;
  logic        in_rd_vec = 1'b0, in_ra_vec = 1'b0, in_rb_vec = 1'b0;
  logic [6:0]  in_vl = '0;
  logic        in_pred_en = 1'b0;
  logic [63:0] in_pred = '0;
  logic        pc_hold, uop_valid, done;
  logic        uop_ready = 1'b1;
  logic [7:0]  uop_op;
  logic [6:0]  uop_rd, uop_ra, uop_rb;
  logic [5:0]  uop_idx;

  int checks = 0;
  int errors = 0;

  vec_elem_seq dut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit enabled(input int e, input int vl, input bit anyv, input bit pen, input logic [63:0] pm);
    if (!anyv) return e == 0;
    return (e < vl) && (!pen || pm[e]);
  endfunction

  task automatic run(input logic [7:0] op, input logic [6:0] rd, input logic [6:0] ra, input logic [6:0] rb,
                     input logic [2:0] vt, input int vl, input bit pen, input logic [63:0] pm,
                     input int rmode, input bit poke);
    bit anyv;
    int nexp, e, got, cyc, donecyc;
    anyv = |vt;
    nexp = 0;
    for (int k = 0; k < 64; k++) if (enabled(k, vl, anyv, pen, pm)) nexp++;
    @(negedge clk);
    in_start = 1'b1; in_op = op; in_rd = rd; in_ra = ra; in_rb = rb;
    in_rd_vec = vt[2]; in_ra_vec = vt[1]; in_rb_vec = vt[0];
    in_vl = 7'(vl); in_pred_en = pen; in_pred = pm;
    @(negedge clk);
    in_start = 1'b0;
    e = 0; got = 0; donecyc = -1;
    while (e < 64 && !enabled(e, vl, anyv, pen, pm)) e++;
    for (cyc = 1; cyc < 200; cyc++) begin
      uop_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : (((cyc * 7) % 3) != 0);
      if (poke && cyc == 2) begin
        in_start = 1'b1; in_vl = 7'd5; in_rd = rd + 7'd9; in_op = ~op; in_pred_en = 1'b0;
      end else in_start = 1'b0;
      #1;
      if (done) begin donecyc = cyc; break; end
      chk(pc_hold == (got < nexp), "R3", "pc_hold during run", pc_hold, got < nexp);
      if (uop_valid && uop_ready) begin
        chk(got < nexp, "R1", "extra element", got, nexp);
        chk(uop_idx == 6'(e), anyv ? "R1" : "R5", "element index", uop_idx, e);
        chk(uop_op == op, "R9", "opcode", uop_op, op);
        chk(uop_rd == (vt[2] ? rd + 7'(e) : rd), vt[2] ? "R1" : "R4", "rd", uop_rd, vt[2] ? rd + 7'(e) : rd);
        chk(uop_ra == (vt[1] ? ra + 7'(e) : ra), vt[1] ? "R1" : "R4", "ra", uop_ra, vt[1] ? ra + 7'(e) : ra);
        chk(uop_rb == (vt[0] ? rb + 7'(e) : rb), vt[0] ? "R1" : "R4", "rb", uop_rb, vt[0] ? rb + 7'(e) : rb);
        if (pen && anyv) chk(pm[e], "R2", "predicate bit of issued element", pm[e], 1);
        got++;
        e++;
        while (e < 64 && !enabled(e, vl, anyv, pen, pm)) e++;
      end
      @(negedge clk);
    end
    in_start = 1'b0;
    chk(donecyc > 0, "R8", "done seen", donecyc, 1);
    chk(got == nexp, anyv ? "R2" : "R5", "issued count", got, nexp);
    chk(!pc_hold && !uop_valid, "R3", "pc_hold at done", pc_hold, 0);
    if (rmode == 0) chk(donecyc == nexp + 1, (vl == 0 && anyv) ? "R7" : "R8", "done cycle", donecyc, nexp + 1);
    if (poke) chk(got == nexp, "R10", "start during run ignored", got, nexp);
    @(negedge clk);
    chk(!done && in_ready, "R8", "done single cycle", done, 0);
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vls[7];
    vls = '{0, 1, 2, 5, 17, 63, 64};
    repeat (3) @(negedge clk);
    chk(!uop_valid && !pc_hold && !done && in_ready, "R3", "reset state", uop_valid, 0);
    rst_n = 1'b1;
    for (int vi = 0; vi < 7; vi++)
      for (int vt = 0; vt < 8; vt++)
        for (int pmode = 0; pmode < 3; pmode++)
          for (int rm = 0; rm < 3; rm++) begin
            logic [63:0] pm;
            pm = (pmode == 1) ? 64'hA5C3_0F81_7E18_3C99 : {$urandom, $urandom};
            run(8'(vi * 31 + vt), 7'(vt * 17 + 100), 7'(vi * 13 + 3), 7'(125 - vt),
                3'(vt), vls[vi], pmode != 0, pm, rm, (vi == 3) && (rm == 1));
          end
    run(8'h5A, 7'd120, 7'd10, 7'd20, 3'b100, 64, 1'b1, 64'h8000_0000_0000_0001, 0, 1'b1);
    run(8'h11, 7'd1, 7'd2, 7'd3, 3'b000, 0, 1'b1, 64'h0, 0, 1'b0);
    run(8'h22, 7'd4, 7'd5, 7'd6, 3'b010, 10, 1'b1, 64'h0, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule